// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides whether one local interrupt controller is a recipient of an inter-processor message. It looks at the message command word, which carries the shorthand and the addressing-mode bit. It also looks at the destination field and at the local unit's own identity: its ID register word, its logical destination register word, its destination format word, and a flag for the wider extended addressing mode. A final flag marks the local unit as the sender of the message. From all of these it produces a single hit bit.

Shorthand codes override normal addressing. When no shorthand is given, the mode bit selects one of two paths. The physical path compares IDs and also honours a broadcast value. The logical path has three forms. Legacy logical addressing is either flat (a bitmask) or cluster (a group nibble plus a member mask), and the format word selects which. Extended mode instead ANDs the whole logical register with the whole destination. All paths are computed in parallel. The result is registered once, so hit follows the inputs one clock later.

Top module: `ipi_dest_match`

## Requirements
- R1: The shorthand is taken from bits 19:18 of cmd_word (0 none, 1 self, 2 all including self, 3 all excluding self), and the mode bit from bit 11 (1 logical, 0 physical). All other command bits have no effect on hit.
- R2: With shorthand 1, hit is 1 exactly when from_self is 1, regardless of destination.
- R3: With shorthand 2, hit is always 1.
- R4: With shorthand 3, hit is 1 exactly when from_self is 0.
- R5: With no shorthand and physical mode, a destination whose low 8 bits are 0xFF always hits.
- R6: With no shorthand and physical mode, hit is 1 when the low 8 bits of dest_field equal id_word bits 31:24. Other bits of both words are ignored.
- R7: Flat logical mode (fmt_word bits 31:28 = 0xF, ext_mode 0) hits when ldr_word bits 31:24 AND the low destination byte is nonzero.
- R8: Cluster logical mode (fmt_word bits 31:28 = 0x0, ext_mode 0) hits when the upper nibbles of the logical ID and the destination byte are equal and their lower nibbles share a set bit.
- R9: In extended mode, logical matching hits when all 32 bits of ldr_word ANDed with all 32 bits of dest_field are nonzero, and fmt_word is ignored.
- R10: In legacy logical mode, a format nibble other than 0xF or 0x0 never hits.
- R11: hit is 0 while rst_n is low, and otherwise shows the match for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 32 | Message command word (shorthand 19:18, mode bit 11) |
| dest_field | input | 32 | Message destination field |
| id_word | input | 32 | Local ID register word, ID in bits 31:24 |
| ldr_word | input | 32 | Local logical destination register word |
| fmt_word | input | 32 | Destination format word, model in bits 31:28 |
| ext_mode | input | 1 | Extended addressing mode enable |
| from_self | input | 1 | The local unit is the message sender |
| hit | output | 1 | Registered match result |

## Verification
The bench builds the block with its default parameters: 32-bit register words, an 8-bit legacy ID, a 4-bit format nibble, and the registered output variant. An even 8-bit ID splits into two 4-bit halves, so cluster matching can be told apart from flat matching. With 32-bit words, extended matching reaches logical bits that legacy matching never looks at. The registered variant turns on the clocked assertions and the one-cycle latency that the reference model tracks on every clock.

// File: rtl/dm_pkg.sv
package dm_pkg;
   typedef enum logic [1:0] {
      SH_NONE    = 2'd0,
      SH_SELF    = 2'd1,
      SH_ALL_INC = 2'd2,
      SH_ALL_EXC = 2'd3
   } short_e;

   localparam int unsigned SH_LSB   = 18;
   localparam int unsigned MODE_POS = 11;
endpackage

// File: rtl/dm_phys_match.sv
module dm_phys_match #(
   parameter int unsigned ID_W = 8
) (
   input  logic [ID_W-1:0] dest_id,
   input  logic [ID_W-1:0] local_id,
   output logic            match
);
   logic is_bcast;
   logic is_equal;

   assign is_bcast = (dest_id == {ID_W{1'b1}});
   assign is_equal = (dest_id == local_id);
   assign match    = is_bcast | is_equal;
endmodule

// File: rtl/dm_logic_match.sv
module dm_logic_match #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned ID_W  = 8,
   parameter int unsigned FMT_W = 4
) (
   input  logic             ext_mode,
   input  logic [REG_W-1:0] dest,
   input  logic [REG_W-1:0] ldr,
   input  logic [FMT_W-1:0] model,
   output logic             match
);
   localparam int unsigned HALF = ID_W / 2;

   logic [ID_W-1:0] lid;
   logic [ID_W-1:0] mda;
   logic            flat_hit;
   logic            clus_hit;
   logic            ext_hit;

   assign lid      = ldr[REG_W-1 -: ID_W];
   assign mda      = dest[ID_W-1:0];
   assign flat_hit = |(lid & mda);
   assign clus_hit = (lid[ID_W-1:HALF] == mda[ID_W-1:HALF]) &&
                     (|(lid[HALF-1:0] & mda[HALF-1:0]));
   assign ext_hit  = |(ldr & dest);

   always_comb begin
      if (ext_mode)                      match = ext_hit;
      else if (model == {FMT_W{1'b1}})   match = flat_hit;
      else if (model == {FMT_W{1'b0}})   match = clus_hit;
      else                               match = 1'b0;
   end
endmodule

// File: rtl/dm_short_sel.sv
module dm_short_sel
   import dm_pkg::*;
(
   input  short_e code,
   input  logic   addr_hit,
   input  logic   from_self,
   output logic   hit
);
   always_comb begin
      unique case (code)
         SH_NONE:    hit = addr_hit;
         SH_SELF:    hit = from_self;
         SH_ALL_INC: hit = 1'b1;
         SH_ALL_EXC: hit = ~from_self;
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
   import dm_pkg::*;
#(
   parameter int unsigned CMD_W   = 32,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned ID_W    = 8,
   parameter int unsigned FMT_W   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic [REG_W-1:0] dest_field,
   input  logic [REG_W-1:0] id_word,
   input  logic [REG_W-1:0] ldr_word,
   input  logic [REG_W-1:0] fmt_word,
   input  logic             ext_mode,
   input  logic             from_self,
   output logic             hit
);
   localparam int unsigned SH_MSB = SH_LSB + 1;

   if (ID_W % 2 != 0) begin : g_chk_id_even
      $error("ID_W must be even for the cluster nibble split");
   end
   if (ID_W >= REG_W || FMT_W >= REG_W) begin : g_chk_fields
      $error("ID_W and FMT_W must be narrower than REG_W");
   end
   if (CMD_W <= SH_MSB + 1) begin : g_chk_cmd
      $error("CMD_W too narrow for the shorthand field");
   end

   short_e          sh;
   logic            logical;
   logic [ID_W-1:0] local_id;
   logic [FMT_W-1:0] model;
   logic            phys_hit;
   logic            log_hit;
   logic            addr_hit;
   logic            comb_hit;
   logic            unused_bits;

   assign sh       = short_e'(cmd_word[SH_MSB:SH_LSB]);
   assign logical  = cmd_word[MODE_POS];
   assign local_id = id_word[REG_W-1 -: ID_W];
   assign model    = fmt_word[REG_W-1 -: FMT_W];
   assign unused_bits = ^{cmd_word[CMD_W-1:SH_MSB+1], cmd_word[SH_LSB-1:MODE_POS+1],
                          cmd_word[MODE_POS-1:0], id_word[REG_W-ID_W-1:0],
                          fmt_word[REG_W-FMT_W-1:0]};

   dm_phys_match #(.ID_W(ID_W)) u_phys (
      .dest_id  (dest_field[ID_W-1:0]),
      .local_id (local_id),
      .match    (phys_hit)
   );

   dm_logic_match #(.REG_W(REG_W), .ID_W(ID_W), .FMT_W(FMT_W)) u_logic (
      .ext_mode (ext_mode),
      .dest     (dest_field),
      .ldr      (ldr_word),
      .model    (model),
      .match    (log_hit)
   );

   assign addr_hit = logical ? log_hit : phys_hit;

   dm_short_sel u_short (
      .code      (sh),
      .addr_hit  (addr_hit),
      .from_self (from_self),
      .hit       (comb_hit)
   );

   if (REG_OUT) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= comb_hit;
      end
      assign hit = hit_q;

      AST_ALL_INC_HITS: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_word[SH_MSB:SH_LSB] == 2'd2) |=> hit)
         else $error("broadcast-with-self did not hit"); // R3
      AST_SELF_ONLY_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_word[SH_MSB:SH_LSB] == 2'd1 && !from_self) |=> !hit)
         else $error("self shorthand hit a non-sender"); // R2
      AST_EXCL_SKIPS_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_word[SH_MSB:SH_LSB] == 2'd3 && from_self) |=> !hit)
         else $error("exclude-self shorthand hit the sender"); // R4
      AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_word[SH_MSB:SH_LSB] == 2'd0 && !cmd_word[MODE_POS] &&
          dest_field[ID_W-1:0] == {ID_W{1'b1}}) |=> hit)
         else $error("physical broadcast missed"); // R5
      AST_BAD_MODEL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_word[SH_MSB:SH_LSB] == 2'd0 && cmd_word[MODE_POS] && !ext_mode &&
          fmt_word[REG_W-1 -: FMT_W] != {FMT_W{1'b1}} &&
          fmt_word[REG_W-1 -: FMT_W] != {FMT_W{1'b0}}) |=> !hit)
         else $error("unknown format model hit"); // R10
   end else begin : g_comb
      assign hit = comb_hit;
   end
endmodule

// File: tb/tb_ipi_dest_match.sv
`timescale 1ns/1ps
module tb_ipi_dest_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cmd_word = '0, dest_field = '0, id_word = '0, ldr_word = '0, fmt_word = '0;
   logic        ext_mode = 1'b0, from_self = 1'b0;
   logic        hit;
   int          tests = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   ipi_dest_match dut (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .dest_field(dest_field),
      .id_word(id_word), .ldr_word(ldr_word), .fmt_word(fmt_word),
      .ext_mode(ext_mode), .from_self(from_self), .hit(hit)
   );

   function automatic logic ref_hit(input logic [31:0] c, d, i, l, f, input logic e, s);
      int unsigned sh = (c >> 18) & 3;
      int unsigned lg = (c >> 11) & 1;
      int unsigned db = d & 32'hFF;
      int unsigned lid = (l >> 24) & 32'hFF;
      int unsigned mdl = (f >> 28) & 32'hF;
      if (sh == 1) return s;
      if (sh == 2) return 1'b1;
      if (sh == 3) return !s;
      if (lg == 0) return (db == 255) || (db == ((i >> 24) & 32'hFF));
      if (e) return (l & d) != 0;
      if (mdl == 15) return (lid & db) != 0;
      if (mdl == 0) return ((lid >> 4) == (db >> 4)) && ((lid & db & 15) != 0);
      return 1'b0;
   endfunction

   function automatic logic [31:0] mk(input int unsigned sh, input int unsigned lg);
      return 32'((sh << 18) | (lg << 11));
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: hit=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic run(input logic [31:0] c, d, i, l, f, input logic e, s, input string tag);
      logic exp;
      cmd_word = c; dest_field = d; id_word = i; ldr_word = l; fmt_word = f;
      ext_mode = e; from_self = s;
      exp = ref_hit(c, d, i, l, f, e, s);
      @(negedge clk);
      check(hit, exp, tag);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      cmd_word = mk(2, 0);
      repeat (3) @(negedge clk);
      check(hit, 1'b0, "R11 reset holds hit low");
      rst_n = 1'b1;

      // latency: hit case, then miss case that must not show early
      run(mk(0, 0), 32'h05, 32'h0500_0000, 0, 0, 0, 0, "R11 first hit");
      cmd_word = mk(1, 0); from_self = 1'b0;
      #2 check(hit, 1'b1, "R11 output stable before edge");
      @(negedge clk);
      check(hit, 1'b0, "R11 new value after one edge");

      run(mk(0, 0) | 32'hFFF3_F7FF, 32'h05, 32'h0500_0000, 0, 0, 0, 0, "R1 stray cmd bits ignored");
      run(mk(0, 1) | 32'h0003_F7FF, 32'h05, 32'h0500_0000, 32'h0, 32'h8000_0000, 0, 0, "R1 mode bit selects logical");
      run(mk(1, 0), 32'h00, 32'h0100_0000, 0, 0, 0, 1, "R2 self to sender");
      run(mk(1, 0), 32'hFF, 32'h0100_0000, 0, 0, 0, 0, "R2 self to non-sender");
      run(mk(2, 1), 32'h00, 0, 0, 32'h8000_0000, 0, 0, "R3 all including self");
      run(mk(2, 0), 32'h00, 0, 0, 0, 0, 1, "R3 all including self, sender");
      run(mk(3, 0), 32'hFF, 0, 0, 0, 0, 1, "R4 exclude self, sender");
      run(mk(3, 0), 32'h00, 0, 0, 0, 0, 0, "R4 exclude self, other");
      run(mk(0, 0), 32'h0000_00FF, 32'h0500_0000, 0, 0, 0, 0, "R5 physical broadcast");
      run(mk(0, 0), 32'hABCD_00FF, 32'h0500_0000, 0, 0, 0, 0, "R5 broadcast upper bits ignored");
      run(mk(0, 0), 32'h07, 32'h0700_0000, 0, 0, 0, 0, "R6 physical equal");
      run(mk(0, 0), 32'h08, 32'h0700_0000, 0, 0, 0, 0, "R6 physical unequal");
      run(mk(0, 0), 32'h07, 32'h0000_0007, 0, 0, 0, 0, "R6 low ID bits ignored");
      run(mk(0, 1), 32'h04, 0, 32'h2400_0000, 32'hF000_0000, 0, 0, "R7 flat overlap");
      run(mk(0, 1), 32'h08, 0, 32'h2400_0000, 32'hF000_0000, 0, 0, "R7 flat disjoint");
      run(mk(0, 1), 32'h33, 0, 32'h3100_0000, 32'h0FFF_FFFF, 0, 0, "R8 cluster hit");
      run(mk(0, 1), 32'h21, 0, 32'h3100_0000, 32'h0FFF_FFFF, 0, 0, "R8 cluster other group");
      run(mk(0, 1), 32'h32, 0, 32'h3100_0000, 32'h0FFF_FFFF, 0, 0, "R8 cluster no shared member");
      run(mk(0, 1), 32'h0000_0100, 0, 32'h0000_0100, 32'hF000_0000, 1, 0, "R9 extended low bits");
      run(mk(0, 1), 32'h0000_0001, 0, 32'h8000_0000, 32'hF000_0000, 1, 0, "R9 extended disjoint");
      run(mk(0, 1), 32'h0001_0000, 0, 32'h0001_0000, 32'h8000_0000, 1, 0, "R9 extended ignores format");
      run(mk(0, 1), 32'hFF, 0, 32'hFF00_0000, 32'h8000_0000, 0, 0, "R10 unknown format model");

      for (int n = 0; n < 600; n++) begin
         logic [31:0] c, d, i, l, f;
         c = $urandom; d = $urandom; i = $urandom; l = $urandom; f = $urandom;
         if (n % 3 == 0) d[7:0] = i[31:24];
         if (n % 4 == 1) f[31:28] = (n % 8 == 1) ? 4'hF : 4'h0;
         if (n % 5 == 2) c[19:18] = 2'b00;
         run(c, d, i, l, f, 1'($urandom), 1'($urandom), "R1 random sweep");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule